// File: doc/BRIEF.md
# Sync-Correcting Video Word Serializer

This block takes parallel video words, one per strobe of the parallel word clock enable. It turns each into a serial bit stream at ten bit-enables per word. As a word is captured, its upper eight bits are examined for the timing-reference reserved patterns of all zeros or all ones. When one is found, the two low bits are overwritten to match. A source that only drives the upper eight bits therefore still yields the correct 10-bit sync codes 000h and 3FFh. A disable input turns this correction off for data streams that do not follow the video word conventions. In that case every word, reserved or not, is serialized exactly as presented.

A one-word holding register sits between the parallel side and the shifter. The shifter pulls the held word on the first bit-enable after the tenth bit of the previous word, so back-to-back words leave no idle bit slot. Each emitted bit is marked by a one-cycle valid strobe. A registered sync flag travels with the word and stays high while the bits of a matching word are being sent.

Top module: `sdi_word_serializer`

## Requirements
- R1: After reset `ser_bit`, `bit_vld` and `sync_seen` are 0. `bit_vld` stays low until a word has been strobed in, even while `bit_en` is high.
- R2: A high `word_stb` captures `word_in` into the holding register at the clock edge. If two words are strobed before the shifter takes one, the later word replaces the earlier, and only the later word is sent.
- R3: With `fix_dis` low, a word whose bits 9..2 are all 0 is sent with bits 1..0 forced to 0, giving 000h.
- R4: With `fix_dis` low, a word whose bits 9..2 are all 1 is sent with bits 1..0 forced to 1, giving 3FFh.
- R5: With `fix_dis` high, every word is sent unchanged, and `sync_seen` stays 0 while it is sent.
- R6: A word whose bits 9..2 are neither all 0 nor all 1 is sent unchanged. An 8-bit source placed on bits 9..2, with bits 1..0 tied to 0, arrives as its byte times four.
- R7: Each word is sent as ten bits, least significant bit first, one bit per cycle with `bit_en` high. `bit_vld` is high in the cycle after each edge at which `bit_en` was high and a bit was emitted, and never otherwise.
- R8: If a word is held when the tenth bit of the current word has gone out, the held word's first bit goes out on the next `bit_en` edge. Words strobed every ten bit slots give one unbroken run of `bit_vld`, ten cycles per word.
- R9: `sync_seen` rises with the first bit of a word that matched a reserved pattern, and holds through all ten bits of that word. It changes only at the next word load. It is cleared by a bit slot that finds no held word.
- R10: A strobe in the same cycle as a load both hands the held word to the shifter and captures the new word. No word is lost or repeated.
- R11: While `bit_en` is low, `ser_bit` holds its value and `bit_vld` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers use its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_in | input | 10 | Parallel video word; an 8-bit source drives bits 9..2 |
| word_stb | input | 1 | Parallel word strobe: capture `word_in` this cycle |
| fix_dis | input | 1 | High disables reserved-word detection and low-bit correction |
| bit_en | input | 1 | Serial bit-rate enable, ten per word period |
| ser_bit | output | 1 | Serial data bit, least significant bit of each word first |
| bit_vld | output | 1 | High for one cycle per emitted serial bit |
| sync_seen | output | 1 | High while the bits of a reserved (sync) word are being sent |

## Verification
Two events can fall in the same cycle: the parallel side strobing a new word into the holding register, and the serial side emptying that register at the start of a word slot. The bench forces this overlap. It strobes one word, then strobes the next word exactly one cycle later, on the edge where the first word loads into the shifter. After that it keeps a ten-cycle cadence, so every later strobe lands on a load edge. Each run of ten valid bits is rebuilt into a word and compared with the expected word sequence, and the complete run must be unbroken and sixty bits long. A dropped or repeated word shows up as a content mismatch, a leftover expected word, or a wrong run length.

// File: rtl/sdi_ser_pkg.sv
package sdi_ser_pkg;

   localparam int SDI_WORD_W = 10;
   localparam int SDI_LOW_W  = 2;

   // Width of a counter that must hold the values 0 .. n-1.
   function automatic int slot_cnt_bits(input int n);
      int w;
      w = 1;
      while ((1 << w) < n) w++;
      return w;
   endfunction

endpackage

// File: rtl/sdi_sync_fix.sv
module sdi_sync_fix #(
   parameter int WORD_W = sdi_ser_pkg::SDI_WORD_W,
   parameter int LOW_W  = sdi_ser_pkg::SDI_LOW_W,
   parameter bit FIX_EN = 1'b1
) (
   input  logic [WORD_W-1:0] raw_word,
   input  logic              fix_dis,
   output logic [WORD_W-1:0] fixed_word,
   output logic              is_sync
);

   localparam int UP_W = WORD_W - LOW_W;

   logic [UP_W-1:0] upper;
   logic            upper_zero;
   logic            upper_ones;

   assign upper      = raw_word[WORD_W-1:LOW_W];
   assign upper_zero = ~|upper;
   assign upper_ones = &upper;

   generate
      if (FIX_EN) begin : g_fix
         always_comb begin
            is_sync    = !fix_dis && (upper_zero || upper_ones);
            fixed_word = raw_word;
            if (is_sync) begin
               fixed_word[LOW_W-1:0] = {LOW_W{upper_ones}};
            end
         end
      end else begin : g_pass
         logic unused_flags;
         assign unused_flags = upper_zero ^ upper_ones ^ fix_dis;
         assign is_sync      = 1'b0;
         assign fixed_word   = raw_word;
      end
   endgenerate

endmodule

// File: rtl/sdi_word_hold.sv
module sdi_word_hold #(
   parameter int WORD_W = sdi_ser_pkg::SDI_WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic [WORD_W-1:0] cap_word,
   input  logic              cap_sync,
   input  logic              take,
   output logic [WORD_W-1:0] held_word,
   output logic              held_sync,
   output logic              held_full
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_word <= '0;
         held_sync <= 1'b0;
         held_full <= 1'b0;
      end else begin
         if (cap) begin
            held_word <= cap_word;
            held_sync <= cap_sync;
            held_full <= 1'b1;
         end else if (take) begin
            held_full <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/sdi_word_shifter.sv
module sdi_word_shifter #(
   parameter int WORD_W    = sdi_ser_pkg::SDI_WORD_W,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic [WORD_W-1:0] src_word,
   input  logic              src_sync,
   input  logic              src_full,
   output logic              take,
   output logic              ser_bit,
   output logic              bit_vld,
   output logic              sync_seen
);

   localparam int CNT_W = sdi_ser_pkg::slot_cnt_bits(WORD_W);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

   logic [WORD_W-1:0] shreg;
   logic [CNT_W-1:0]  idx;
   logic              slot_idle;
   logic              head_src;
   logic              head_sh;
   logic [WORD_W-1:0] rest_src;
   logic [WORD_W-1:0] rest_sh;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign head_src = src_word[0];
         assign rest_src = {1'b0, src_word[WORD_W-1:1]};
         assign head_sh  = shreg[0];
         assign rest_sh  = {1'b0, shreg[WORD_W-1:1]};
      end else begin : g_msb
         assign head_src = src_word[WORD_W-1];
         assign rest_src = {src_word[WORD_W-2:0], 1'b0};
         assign head_sh  = shreg[WORD_W-1];
         assign rest_sh  = {shreg[WORD_W-2:0], 1'b0};
      end
   endgenerate

   assign slot_idle = (idx == '0);
   assign take      = bit_en && slot_idle && src_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg     <= '0;
         idx       <= '0;
         ser_bit   <= 1'b0;
         bit_vld   <= 1'b0;
         sync_seen <= 1'b0;
      end else if (!bit_en) begin
         bit_vld <= 1'b0;
      end else if (slot_idle) begin
         if (src_full) begin
            ser_bit   <= head_src;
            shreg     <= rest_src;
            idx       <= CNT_W'(1);
            bit_vld   <= 1'b1;
            sync_seen <= src_sync;
         end else begin
            bit_vld   <= 1'b0;
            sync_seen <= 1'b0;
         end
      end else begin
         ser_bit <= head_sh;
         shreg   <= rest_sh;
         idx     <= (idx == LAST_IDX) ? '0 : idx + CNT_W'(1);
         bit_vld <= 1'b1;
      end
   end

endmodule

// File: rtl/sdi_word_serializer.sv
module sdi_word_serializer #(
   parameter int WORD_W      = sdi_ser_pkg::SDI_WORD_W,
   parameter int LOW_W       = sdi_ser_pkg::SDI_LOW_W,
   parameter bit SYNC_FIX_EN = 1'b1,
   parameter bit LSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word_in,
   input  logic              word_stb,
   input  logic              fix_dis,
   input  logic              bit_en,
   output logic              ser_bit,
   output logic              bit_vld,
   output logic              sync_seen
);

   generate
      if (LOW_W < 1 || LOW_W >= WORD_W - 1) begin : g_bad_low
         $error("sdi_word_serializer: LOW_W must leave at least two detect bits");
      end
      if (WORD_W < 3) begin : g_bad_word
         $error("sdi_word_serializer: WORD_W too small");
      end
   endgenerate

   logic [WORD_W-1:0] fixed_word;
   logic              fixed_sync;
   logic [WORD_W-1:0] held_word;
   logic              held_sync;
   logic              held_full;
   logic              take;

   sdi_sync_fix #(
      .WORD_W (WORD_W),
      .LOW_W  (LOW_W),
      .FIX_EN (SYNC_FIX_EN)
   ) fix_i (
      .raw_word   (word_in),
      .fix_dis    (fix_dis),
      .fixed_word (fixed_word),
      .is_sync    (fixed_sync)
   );

   sdi_word_hold #(
      .WORD_W (WORD_W)
   ) hold_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap       (word_stb),
      .cap_word  (fixed_word),
      .cap_sync  (fixed_sync),
      .take      (take),
      .held_word (held_word),
      .held_sync (held_sync),
      .held_full (held_full)
   );

   sdi_word_shifter #(
      .WORD_W    (WORD_W),
      .LSB_FIRST (LSB_FIRST)
   ) shift_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_en    (bit_en),
      .src_word  (held_word),
      .src_sync  (held_sync),
      .src_full  (held_full),
      .take      (take),
      .ser_bit   (ser_bit),
      .bit_vld   (bit_vld),
      .sync_seen (sync_seen)
   );

endmodule

// File: rtl/sdi_word_serializer_chk.sv
module sdi_word_serializer_chk #(
   parameter int WORD_W      = 10,
   parameter int LOW_W       = 2,
   parameter bit SYNC_FIX_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [WORD_W-1:0] word_in,
   input logic              word_stb,
   input logic              fix_dis,
   input logic              bit_en,
   input logic              ser_bit,
   input logic              bit_vld,
   input logic              sync_seen,
   input logic [WORD_W-1:0] held_word,
   input logic              held_full
);

   logic up_zero;
   logic up_ones;
   assign up_zero = (word_in[WORD_W-1:LOW_W] == '0);
   assign up_ones = (&word_in[WORD_W-1:LOW_W]);

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |-> (!bit_vld && !ser_bit && !sync_seen));

   assert_valid_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bit_vld |-> $past(bit_en));

   assert_bit_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ser_bit) |-> bit_vld);

   assert_flag_moves_on_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sync_seen) |-> $past(bit_en));

   assert_strobe_fills_R10: assert property (@(posedge clk) disable iff (!rst_n)
      word_stb |=> held_full);

   assert_disable_passes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (word_stb && fix_dis) |=> (held_word == $past(word_in)));

   generate
      if (SYNC_FIX_EN) begin : g_fix_props
         assert_zero_forced_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (word_stb && !fix_dis && up_zero) |=> (held_word == '0));

         assert_ones_forced_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (word_stb && !fix_dis && up_ones) |=> (&held_word));
      end
   endgenerate

endmodule

bind sdi_word_serializer sdi_word_serializer_chk #(
   .WORD_W      (WORD_W),
   .LOW_W       (LOW_W),
   .SYNC_FIX_EN (SYNC_FIX_EN)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .word_in   (word_in),
   .word_stb  (word_stb),
   .fix_dis   (fix_dis),
   .bit_en    (bit_en),
   .ser_bit   (ser_bit),
   .bit_vld   (bit_vld),
   .sync_seen (sync_seen),
   .held_word (held_word),
   .held_full (held_full)
);

// File: tb/sdi_word_serializer_tb_top.sv
`timescale 1ns/1ps
module sdi_word_serializer_tb_top;

   localparam int W = 10;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [W-1:0] word_in;
   logic         word_stb;
   logic         fix_dis;
   logic         bit_en;
   logic         ser_bit;
   logic         bit_vld;
   logic         sync_seen;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   // expected word queue
   logic [W-1:0] exp_w [0:4095];
   bit           exp_s [0:4095];
   string        exp_t [0:4095];
   int wr = 0;
   int rd = 0;

   // receiver state
   int           en_mode = 1;   // 0 off, 1 every cycle, 2 every third cycle
   int           phase   = 0;
   logic         en_prev;
   logic         last_ser = 1'b0;
   logic [W-1:0] acc = '0;
   int           nbit = 0;
   bit           sync_bad = 1'b0;
   int           run_len = 0;
   int           last_run = 0;

   always #2.5 clk = ~clk;

   sdi_word_serializer dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .word_in   (word_in),
      .word_stb  (word_stb),
      .fix_dis   (fix_dis),
      .bit_en    (bit_en),
      .ser_bit   (ser_bit),
      .bit_vld   (bit_vld),
      .sync_seen (sync_seen)
   );

   function automatic logic [W-1:0] expect_word(input logic [W-1:0] w, input bit dis);
      if (!dis && w[9:2] == 8'h00) return 10'h000;
      if (!dis && w[9:2] == 8'hFF) return 10'h3FF;
      return w;
   endfunction

   function automatic bit expect_sync(input logic [W-1:0] w, input bit dis);
      return !dis && (w[9:2] == 8'h00 || w[9:2] == 8'hFF);
   endfunction

   function automatic string class_tag(input logic [W-1:0] w, input bit dis);
      if (dis) return "R5";
      if (w[9:2] == 8'h00) return "R3";
      if (w[9:2] == 8'hFF) return "R4";
      return "R6";
   endfunction

   task automatic check(input bit ok, input string req, input int got, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   // one cycle: strobe a word, optionally record it as expected
   task automatic send(input logic [W-1:0] w, input bit dis, input bit push, input string tag);
      word_in  = w;
      fix_dis  = dis;
      word_stb = 1'b1;
      if (push) begin
         exp_w[wr] = expect_word(w, dis);
         exp_s[wr] = expect_sync(w, dis);
         exp_t[wr] = (tag == "") ? class_tag(w, dis) : tag;
         wr++;
      end
      @(negedge clk);
      word_stb = 1'b0;
   endtask

   // receiver and bit-enable generator, all at the falling edge
   always @(negedge clk) begin
      en_prev = bit_en;
      if (rst_n === 1'b1) begin
         if (bit_vld && !en_prev) begin
            tests++; fails++;
            $display("FAIL R7: bit_vld got 1 expected 0 with bit_en low");
         end
         if (!bit_vld && ser_bit !== last_ser) begin
            tests++; fails++;
            $display("FAIL R11: ser_bit got %0b expected %0b", ser_bit, last_ser);
         end
         if (bit_vld) begin
            run_len++;
            if (rd == wr) begin
               tests++; fails++;
               $display("FAIL R1/R8: unexpected bit got 1 expected no bit");
            end else begin
               acc[nbit] = ser_bit;
               if (sync_seen !== exp_s[rd]) sync_bad = 1'b1;
               nbit++;
               if (nbit == W) begin
                  tests += 2;
                  if (acc !== exp_w[rd]) begin
                     fails++;
                     $display("FAIL %s/R7: word got %0h expected %0h", exp_t[rd], acc, exp_w[rd]);
                  end
                  if (sync_bad) begin
                     fails++;
                     $display("FAIL %s/R9: sync_seen got wrong expected %0b", exp_t[rd], exp_s[rd]);
                  end
                  rd++;
                  nbit = 0;
                  sync_bad = 1'b0;
               end
            end
         end else if (run_len != 0) begin
            last_run = run_len;
            run_len = 0;
         end
      end
      last_ser = ser_bit;
      case (en_mode)
         0: bit_en = 1'b0;
         1: bit_en = 1'b1;
         default: begin
            phase  = (phase == 2) ? 0 : phase + 1;
            bit_en = (phase == 0);
         end
      endcase
   end

   initial begin
      rst_n = 1'b0; word_stb = 1'b0; word_in = '0; fix_dis = 1'b0; bit_en = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1: idle after reset, enable running, nothing strobed
      repeat (20) @(negedge clk);
      check(bit_vld == 1'b0 && ser_bit == 1'b0 && sync_seen == 1'b0, "R1",
            {bit_vld, ser_bit, sync_seen}, 0);

      // exhaustive sweep, correction on then off, one word per ten slots (R3 R4 R5 R6 R8)
      for (int i = 0; i < 2048; i++) begin
         send(i[9:0], i >= 1024, 1'b1, "");
         repeat (9) @(negedge clk);
      end
      repeat (30) @(negedge clk);
      check(last_run == 20480, "R8", last_run, 20480);
      check(rd == wr, "R8", wr - rd, 0);

      // R9: flag high mid-word, cleared by an empty slot
      send(10'h3FC, 1'b0, 1'b1, "R9");
      repeat (5) @(negedge clk);
      check(sync_seen == 1'b1, "R9", sync_seen, 1);
      repeat (30) @(negedge clk);
      check(sync_seen == 1'b0, "R9", sync_seen, 0);

      // R11: slow enable, one bit every third cycle
      en_mode = 2;
      for (int i = 0; i < 40; i++) begin
         send(W'((i * 97 + 1) % 1024), i[0], 1'b1, "");
         repeat (29) @(negedge clk);
      end
      repeat (60) @(negedge clk);
      check(rd == wr, "R11", wr - rd, 0);

      // R2: two strobes while the shifter is frozen, later one wins
      en_mode = 0;
      repeat (3) @(negedge clk);
      send(10'h155, 1'b0, 1'b0, "R2");
      send(10'h2AA, 1'b0, 1'b1, "R2");
      repeat (5) @(negedge clk);
      check(bit_vld == 1'b0, "R11", bit_vld, 0);
      en_mode = 1;
      repeat (30) @(negedge clk);
      check(rd == wr, "R2", wr - rd, 0);

      // R10: every strobe after the first lands on a load edge
      send(10'h123, 1'b0, 1'b1, "R10");
      send(10'h3FD, 1'b0, 1'b1, "R10");
      for (int k = 0; k < 4; k++) begin
         repeat (9) @(negedge clk);
         send(W'(10'h0A5 + k * 10'h111), 1'b0, 1'b1, "R10");
      end
      repeat (30) @(negedge clk);
      check(rd == wr, "R10", wr - rd, 0);
      check(last_run == 60, "R8", last_run, 60);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL R8: watchdog got hang expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule